// File: doc/BRIEF.md
# Switch Shadow Override Controller

This block sits on a byte-wide memory-mapped board-control bus. It lets software override the board's configuration DIP switches bit by bit. There are eight 8-bit switches. Each switch has a shadow byte and a per-bit enable byte. When an enable bit is 1, the shadow bit replaces the physical switch bit. When it is 0, the synchronized physical bit passes through.

Two software triggers restart the board.

- **Hard trigger:** a write to the hard-reset offset. It captures the raw synchronized switch values and ignores every enable.
- **Override trigger:** a rising edge on bit 0 of the control byte. It captures the merged, overridden values.

Either trigger freezes the captured 64-bit configuration onto an output and then drives a fixed-length board reset pulse. The boot source is decoded from the upper nibble of switch 7 in that captured configuration. Software selects an alternate flash bank as follows:

1. Write 0x20 into switch 7's shadow byte.
2. Enable the four upper bits of switch 7.
3. Pull the override trigger.

Clearing only those four enable bits returns the board to the switch setting.

The bus is plain synchronous strobes with no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. A read registers the data on the edge where `bus_rd` is high, so it is visible one cycle later. `bus_rdata` holds between reads.

Top module: `ssw_ctrl`

## Requirements
- R1: After `rst_n` is released, every shadow and enable byte reads 0x00, `board_rst` is 0 and `cfg_latched` is all zeros.
- R2: Offsets 0x00, 0x01 and 0x02 read the parameters `ID_VAL`, `ARCH_VAL` and `FVER_VAL`. Read data appears on `bus_rdata` the cycle after the `bus_rd` strobe.
- R3: Switch x (1..8) has its shadow byte at offset 0x20+2*(x-1) and its enable byte at 0x21+2*(x-1). Both read back the last value written.
- R4: For every bit, the effective value is the shadow bit when the enable bit is 1, and the synchronized physical bit otherwise.
- R5: A write of any value to offset 0x04 captures the synchronized physical switches into `cfg_latched`, ignoring all enables. Switch x occupies bits [8x-1:8x-8].
- R6: A write to offset 0x10 whose bit 0 is 1 while the stored control bit 0 is 0 captures the effective values into `cfg_latched`. A write with bit 0 = 1 while the stored bit is already 1 starts nothing. Offset 0x10 reads back the last byte written.
- R7: `board_rst` rises on the clock edge that accepts a trigger and stays high for exactly `RST_CYCLES` cycles (default 16).
- R8: While `board_rst` is high, triggers are ignored. `cfg_latched` does not change and the pulse is not lengthened.
- R9: The boot field is `cfg_latched[55:52]` (switch 7, bits 7:4). `boot_emul` is 1 when the field is 8 or more. `boot_vbank` equals the field's low two bits.
- R10: Reads of offset 0x04 and of every offset not listed above return 0x00. Writes to unlisted offsets change nothing readable.
- R11: Shadow, enable and control bytes keep their values across both software-triggered resets.
- R12: Each physical switch input passes through two flops. A capture on the first clock edge after an input change still records the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sw_phys | input | 64 | Physical switch bits; switch x at [8x-1:8x-8] |
| board_rst | output | 1 | Board reset pulse |
| cfg_latched | output | 64 | Configuration captured at the last trigger |
| boot_emul | output | 1 | Boot from external emulator |
| boot_vbank | output | 2 | Virtual flash bank number |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that `sw_phys` moves only between clock edges. The hard-capture property compares against the synchronizer's second stage, so it relies on nothing upstream of that flop.

The bench drives every strobe, address and switch value on the falling edge and issues one access per task call, so neither condition can be broken. Switch values are left to settle for at least three cycles before a trigger, except in the one test that deliberately captures in the same cycle as a change.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_ARCH  = 8'h01;
  localparam logic [7:0] OFS_FVER  = 8'h02;
  localparam logic [7:0] OFS_HRST  = 8'h04;
  localparam logic [7:0] OFS_CTL   = 8'h10;
  localparam logic [7:0] OFS_PAIRS = 8'h20;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_HARD = 2'd1,
    TRIG_OVR  = 2'd2
  } trig_e;
endpackage

// File: rtl/ssw_sync.sv
module ssw_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ssw_bank.sv
module ssw_bank
  import ssw_pkg::*;
#(
  parameter int         N_SW     = 8,
  parameter logic [7:0] ID_VAL   = 8'hA5,
  parameter logic [7:0] ARCH_VAL = 8'h13,
  parameter logic [7:0] FVER_VAL = 8'h07
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [7:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [N_SW*BYTE_W-1:0]   phys_q,
  output logic [N_SW*BYTE_W-1:0]   eff,
  output trig_e                    trig
);
  localparam int ALL_W = N_SW * BYTE_W;

  logic [ALL_W-1:0] sh_all;
  logic [ALL_W-1:0] en_all;
  logic [7:0]       ctl_q;
  logic [7:0]       rd_val;

  for (genvar g = 0; g < N_SW; g++) begin : g_sw
    localparam logic [7:0] SH_OFS = 8'(int'(OFS_PAIRS) + 2 * g);
    localparam logic [7:0] EN_OFS = 8'(int'(OFS_PAIRS) + 2 * g + 1);
    logic [7:0] sh_r;
    logic [7:0] en_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_r <= '0;
        en_r <= '0;
      end else if (bus_wr) begin
        if (bus_addr == SH_OFS) sh_r <= bus_wdata;
        if (bus_addr == EN_OFS) en_r <= bus_wdata;
      end
    end

    assign sh_all[g*BYTE_W +: BYTE_W] = sh_r;
    assign en_all[g*BYTE_W +: BYTE_W] = en_r;
    assign eff[g*BYTE_W +: BYTE_W]    = (sh_r & en_r) | (phys_q[g*BYTE_W +: BYTE_W] & ~en_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctl_q <= '0;
    else if (bus_wr && bus_addr == OFS_CTL)  ctl_q <= bus_wdata;
  end

  always_comb begin
    trig = TRIG_NONE;
    if (bus_wr && bus_addr == OFS_HRST)
      trig = TRIG_HARD;
    else if (bus_wr && bus_addr == OFS_CTL && bus_wdata[0] && !ctl_q[0])
      trig = TRIG_OVR;
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_ID:   rd_val = ID_VAL;
      OFS_ARCH: rd_val = ARCH_VAL;
      OFS_FVER: rd_val = FVER_VAL;
      OFS_CTL:  rd_val = ctl_q;
      default: begin
        for (int i = 0; i < N_SW; i++) begin
          if (bus_addr == 8'(int'(OFS_PAIRS) + 2 * i))     rd_val = sh_all[i*BYTE_W +: BYTE_W];
          if (bus_addr == 8'(int'(OFS_PAIRS) + 2 * i + 1)) rd_val = en_all[i*BYTE_W +: BYTE_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/ssw_rstseq.sv
module ssw_rstseq
  import ssw_pkg::*;
#(
  parameter int CFG_W      = 64,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trig_e            trig,
  input  logic [CFG_W-1:0] raw_cfg,
  input  logic [CFG_W-1:0] eff_cfg,
  output logic [CFG_W-1:0] cfg_q,
  output logic             busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (trig != TRIG_NONE) begin
      cfg_q <= (trig == TRIG_HARD) ? raw_cfg : eff_cfg;
      busy  <= 1'b1;
      cnt_q <= CNT_LOAD;
    end
  end
endmodule

// File: rtl/ssw_ctrl.sv
module ssw_ctrl
  import ssw_pkg::*;
#(
  parameter int         N_SW       = 8,
  parameter int         RST_CYCLES = 16,
  parameter int         BOOT_SW    = 6,
  parameter logic [7:0] ID_VAL     = 8'hA5,
  parameter logic [7:0] ARCH_VAL   = 8'h13,
  parameter logic [7:0] FVER_VAL   = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [7:0]             bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [N_SW*8-1:0]      sw_phys,
  output logic                   board_rst,
  output logic [N_SW*8-1:0]      cfg_latched,
  output logic                   boot_emul,
  output logic [1:0]             boot_vbank
);
  localparam int ALL_W   = N_SW * BYTE_W;
  localparam int FLD_TOP = BOOT_SW * BYTE_W + BYTE_W - 1;

  logic [ALL_W-1:0] phys_q;
  logic [ALL_W-1:0] eff;
  trig_e            trig;
  logic [3:0]       boot_fld;

  ssw_sync #(.W(ALL_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sw_phys),
    .q     (phys_q)
  );

  ssw_bank #(
    .N_SW     (N_SW),
    .ID_VAL   (ID_VAL),
    .ARCH_VAL (ARCH_VAL),
    .FVER_VAL (FVER_VAL)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .phys_q    (phys_q),
    .eff       (eff),
    .trig      (trig)
  );

  ssw_rstseq #(
    .CFG_W      (ALL_W),
    .RST_CYCLES (RST_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .raw_cfg (phys_q),
    .eff_cfg (eff),
    .cfg_q   (cfg_latched),
    .busy    (board_rst)
  );

  assign boot_fld   = cfg_latched[FLD_TOP -: 4];
  assign boot_emul  = boot_fld[3];
  assign boot_vbank = boot_fld[1:0];
endmodule

// File: rtl/ssw_ctrl_chk.sv
module ssw_ctrl_chk #(
  parameter int N_SW       = 8,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [N_SW*8-1:0] phys_q,
  input logic              board_rst,
  input logic [N_SW*8-1:0] cfg_latched,
  input logic              boot_emul,
  input logic [1:0]        boot_vbank
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (board_rst) hi_len <= hi_len + 16'd1;
    else                hi_len <= '0;
  end

  function automatic logic reads_zero(input logic [7:0] a);
    return !(a <= 8'h02 || a == 8'h10 || (int'(a) >= 32 && int'(a) < 32 + 2 * N_SW));
  endfunction

  p_hard_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04 && !board_rst) |=> (cfg_latched == $past(phys_q)));

  p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04 && !board_rst) |=> board_rst);

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(board_rst) |-> (hi_len == 16'(RST_CYCLES)));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (board_rst && $past(board_rst)) |-> $stable(cfg_latched));

  p_boot_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_emul == cfg_latched[55]) && (boot_vbank == cfg_latched[53:52]));

  p_zero_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && reads_zero(bus_addr)) |=> (bus_rdata == 8'h00));
endmodule

bind ssw_ctrl ssw_ctrl_chk #(
  .N_SW       (N_SW),
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .phys_q      (phys_q),
  .board_rst   (board_rst),
  .cfg_latched (cfg_latched),
  .boot_emul   (boot_emul),
  .boot_vbank  (boot_vbank)
);

// File: tb/tb_ssw_ctrl.sv
`timescale 1ns/1ps
module tb_ssw_ctrl;
  localparam int N_VEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] sw_phys = '0;
  logic        board_rst;
  logic [63:0] cfg_latched;
  logic        boot_emul;
  logic [1:0]  boot_vbank;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  // {op(1=write,0=read+compare), addr, data}
  localparam logic [16:0] VEC [N_VEC] = '{
    {1'b0, 8'h00, 8'hA5}, // R2
    {1'b0, 8'h01, 8'h13}, // R2
    {1'b0, 8'h02, 8'h07}, // R2
    {1'b1, 8'h20, 8'h5A}, // R3 switch 1 shadow
    {1'b1, 8'h21, 8'hC3}, // R3 switch 1 enable
    {1'b1, 8'h2F, 8'h81}, // R3 switch 8 enable
    {1'b0, 8'h20, 8'h5A},
    {1'b0, 8'h21, 8'hC3},
    {1'b0, 8'h2F, 8'h81},
    {1'b1, 8'h03, 8'hFF}, // R10 reserved write
    {1'b1, 8'h30, 8'hEE}, // R10 past pair window
    {1'b0, 8'h03, 8'h00},
    {1'b0, 8'h30, 8'h00},
    {1'b0, 8'h04, 8'h00}  // R10 hard-reset offset reads zero
  };

  ssw_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sw_phys     (sw_phys),
    .board_rst   (board_rst),
    .cfg_latched (cfg_latched),
    .boot_emul   (boot_emul),
    .boot_vbank  (boot_vbank)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // counts remaining high samples of board_rst, including the current one
  task automatic drain(output int n);
    n = 0;
    while (board_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] merge(input logic [63:0] p, input logic [63:0] s, input logic [63:0] e);
    return (s & e) | (p & ~e);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  rv;
    logic [63:0] sh, en, p, exp;
    int          n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 board_rst", 64'(board_rst), 64'd0);
    check("R1 cfg_latched", cfg_latched, 64'd0);
    for (int i = 0; i < 16; i++) begin
      rd(8'(32 + i), rv);
      check("R1 pair reg", 64'(rv), 64'd0);
    end

    // Table walk: R2, R3, R10
    for (int v = 0; v < N_VEC; v++) begin
      if (VEC[v][16]) wr(VEC[v][15:8], VEC[v][7:0]);
      else begin
        rd(VEC[v][15:8], rv);
        check("R2/R3/R10 table", 64'(rv), 64'(VEC[v][7:0]));
      end
    end
    check("R10 no reset from reserved write", 64'(board_rst), 64'd0);

    // R3/R4: program all pairs, override capture
    p = 64'h7E81_3C3C_AA55_0FF0;
    sw_phys = p;
    sh = '0; en = '0;
    for (int i = 0; i < 8; i++) begin
      sh[i*8 +: 8] = 8'(8'h37 * (i + 1));
      en[i*8 +: 8] = 8'(8'h1D << (i % 4)) ^ 8'(i);
      wr(8'(32 + 2 * i), sh[i*8 +: 8]);
      wr(8'(33 + 2 * i), en[i*8 +: 8]);
    end
    for (int i = 0; i < 8; i++) begin
      rd(8'(32 + 2 * i), rv);
      check("R3 shadow readback", 64'(rv), 64'(sh[i*8 +: 8]));
      rd(8'(33 + 2 * i), rv);
      check("R3 enable readback", 64'(rv), 64'(en[i*8 +: 8]));
    end
    wr(8'h10, 8'h00);
    wr(8'h10, 8'h01);
    check("R6 capture on rise", cfg_latched, merge(p, sh, en));
    check("R4 merged value", cfg_latched, merge(p, sh, en));
    drain(n);
    check("R7 override pulse length", 64'(n), 64'd16);
    rd(8'h10, rv);
    check("R6 control readback", 64'(rv), 64'h01);

    // R6: writing 1 again does not retrigger
    sw_phys = ~p;
    repeat (3) @(negedge clk);
    wr(8'h10, 8'h01);
    check("R6 no retrigger", 64'(board_rst), 64'd0);
    check("R6 cfg unchanged", cfg_latched, merge(p, sh, en));

    // R5 hard capture ignores enables
    p = 64'h1234_5678_9ABC_DEF0;
    sw_phys = p;
    repeat (3) @(negedge clk);
    wr(8'h04, 8'h5C);
    check("R5 hard capture", cfg_latched, p);
    check("R7 pulse starts", 64'(board_rst), 64'd1);
    drain(n);
    check("R7 hard pulse length", 64'(n), 64'd16);

    // R8: trigger inside pulse ignored
    wr(8'h10, 8'h00);
    wr(8'h10, 8'h01);
    exp = merge(p, sh, en);
    sw_phys = 64'hFFFF_0000_FFFF_0000;
    wr(8'h04, 8'h00);
    drain(n);
    check("R8 pulse not extended", 64'(n + 1), 64'd16);
    check("R8 cfg unchanged", cfg_latched, exp);

    // R11 registers kept across resets
    rd(8'h2C, rv);
    check("R11 shadow kept", 64'(rv), 64'(sh[55:48]));
    rd(8'h2D, rv);
    check("R11 enable kept", 64'(rv), 64'(en[55:48]));

    // R9 boot decode: alternate bank 2
    p = 64'h0070_0000_0000_0000;
    sw_phys = p;
    wr(8'h2C, 8'h20);
    wr(8'h2D, 8'hF5);
    sh[55:48] = 8'h20; en[55:48] = 8'hF5;
    wr(8'h10, 8'h00);
    wr(8'h10, 8'h01);
    check("R9 vbank alt", 64'(boot_vbank), 64'd2);
    check("R9 emul low field", 64'(boot_emul), 64'd0);
    drain(n);

    wr(8'h2C, 8'hA0);
    wr(8'h10, 8'h00);
    wr(8'h10, 8'h01);
    check("R9 emul field>=8", 64'(boot_emul), 64'd1);
    check("R9 vbank of 0xA", 64'(boot_vbank), 64'd2);
    drain(n);

    // R4 revert: clear only the upper enable bits of switch 7
    wr(8'h2D, 8'h05);
    sh[55:48] = 8'hA0; en[55:48] = 8'h05;
    wr(8'h10, 8'h00);
    wr(8'h10, 8'h01);
    check("R4 revert byte", 64'(cfg_latched[55:48]), 64'(merge(p, sh, en) >> 48) & 64'hFF);
    check("R9 physical field 7", 64'(boot_vbank), 64'd3);
    drain(n);

    // R12 synchronizer delay
    p = 64'h0F0F_0F0F_0F0F_0F0F;
    sw_phys = p;
    repeat (3) @(negedge clk);
    sw_phys = ~p;
    wr(8'h04, 8'h00);
    check("R12 old value captured", cfg_latched, p);
    drain(n);
    wr(8'h04, 8'h00);
    check("R12 new value after settle", cfg_latched, ~p);
    drain(n);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule